// File: doc/BRIEF.md
# I2C Master Control Register Front End

This block holds the 8-bit control register of a single-master I2C interface and turns its contents into command requests for a separate bit-level engine. Software reads and writes the register over a simple CPU-side strobe interface. The engine reports back when a start or stop condition has gone out, whether it is in master mode, whether the bus is busy, and which event flags are pending. From these reports the block clears register bits in hardware, asks for a start, a repeated start or a stop, drives the acknowledge enable, raises the interrupt and decides when SCL must be held low.

Turning the peripheral on takes two writes. The first write only sets the enable bit. The second write loads the command bits. Disabling clears every control bit except the stop request, and it releases the pins. The meaning of the start bit depends on the engine's mode. In idle mode it waits for a free bus and then asks for a start. In master mode it asks for a repeated start, and a pending stop takes priority over it.

Top module: `i2cm_ctrl_front`

## Requirements
- R1: After reset the register reads 00h. Bits 7, 6 and 4 always read 0. The field positions are: enable at bit 5, start at bit 3, acknowledge at bit 2, stop at bit 1, interrupt enable at bit 0.
- R2: A write made while the enable bit is 0 sets only the enable bit, and only if bit 5 of the written data is 1. Every other written bit is ignored.
- R3: A write made while enabled with bit 5 = 1 loads start, acknowledge, stop and interrupt enable from the written data. The new value is visible on the read port one cycle later.
- R4: A write made while enabled with bit 5 = 0 disables the block. It clears start, acknowledge and interrupt enable, leaves stop unchanged, and raises pins_release two cycles after the write.
- R5: A start-sent report clears the start bit. When it arrives in the same cycle as a write that sets start, the clear wins.
- R6: req_start is 1 one cycle after enable = 1, start = 1, master = 0 and busy = 0 all hold. Otherwise it is 0.
- R7: req_rstart is 1 one cycle after enable = 1, start = 1, master = 1 and stop = 0 all hold. A pending stop suppresses the repeated start.
- R8: req_stop is 1 one cycle after enable = 1, stop = 1 and master = 1 all hold. A stop-sent report clears the stop bit, including while the block is disabled.
- R9: ack_en follows the acknowledge bit with one cycle of delay.
- R10: irq is 1 one cycle after enable = 1, interrupt enable = 1 and at least one event flag is 1. It is 0 when interrupt enable is 0.
- R11: scl_hold is 1 one cycle after enable = 1 and any of the start-bit, byte-done or second-event flags is 1. This does not depend on interrupt enable.
- R12: While enabled, a write with bit 5 = 1 and bit 1 = 0 clears a pending stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Live register value, reserved bits zero |
| eng_start_sent | input | 1 | Engine has issued the start condition |
| eng_stop_sent | input | 1 | Engine has issued the stop condition |
| eng_master | input | 1 | Engine is in master mode |
| eng_bus_busy | input | 1 | Bus is busy |
| eng_flags | input | NUM_EVT | Event flags: bit0 start-bit, bit1 byte done, bit2 second event |
| req_start | output | 1 | Request a start when the bus is free |
| req_rstart | output | 1 | Request a repeated start |
| req_stop | output | 1 | Request a stop |
| ack_en | output | 1 | Return an acknowledge after received bytes |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Hold SCL low |
| pins_release | output | 1 | Release all I2C outputs |

## Verification
The assertions assume that the engine sends a start-sent or stop-sent report only as a single-cycle strobe, and that the event flags are plain levels with no ordering constraint. They also assume that cpu_wdata matters only in cycles where cpu_wr is high. The bench drives every input on the falling clock edge and raises each report strobe for exactly one cycle. It sweeps all 256 write values in both the disabled and the enabled state. It covers every combination of mode, busy, start and stop, and every combination of flags with interrupt enable on and off.

// File: rtl/i2cm_ctrl_pkg.sv
package i2cm_ctrl_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_PE  = 5;
  localparam int BIT_STA = 3;
  localparam int BIT_ACK = 2;
  localparam int BIT_STO = 1;
  localparam int BIT_ITE = 0;

  typedef struct packed {
    logic pe;
    logic sta;
    logic ack;
    logic sto;
    logic ite;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_PE]  = c.pe;
    v[BIT_STA] = c.sta;
    v[BIT_ACK] = c.ack;
    v[BIT_STO] = c.sto;
    v[BIT_ITE] = c.ite;
    return v;
  endfunction
endpackage

// File: rtl/i2cm_ctrl_reg.sv
module i2cm_ctrl_reg
  import i2cm_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             start_sent,
  input  logic             stop_sent,
  output ctrl_t            ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (wr) begin
        if (!ctrl.pe) begin
          if (wdata[BIT_PE]) ctrl.pe <= 1'b1;
        end else if (wdata[BIT_PE]) begin
          ctrl.sta <= wdata[BIT_STA];
          ctrl.ack <= wdata[BIT_ACK];
          ctrl.sto <= wdata[BIT_STO];
          ctrl.ite <= wdata[BIT_ITE];
        end else begin
          ctrl.pe  <= 1'b0;
          ctrl.sta <= 1'b0;
          ctrl.ack <= 1'b0;
          ctrl.ite <= 1'b0;
        end
      end
      // hardware clears take priority over a same-cycle write
      if (start_sent) ctrl.sta <= 1'b0;
      if (stop_sent)  ctrl.sto <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_cmd_seq.sv
module i2cm_cmd_seq
  import i2cm_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  master,
  input  logic  busy,
  output logic  req_start,
  output logic  req_rstart,
  output logic  req_stop,
  output logic  ack_en,
  output logic  pins_release
);
  logic idle_go, rep_go, stop_go;

  always_comb begin
    idle_go = ctrl.pe && ctrl.sta && !master && !busy;
    rep_go  = ctrl.pe && ctrl.sta && master && !ctrl.sto;
    stop_go = ctrl.pe && ctrl.sto && master;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_start    <= 1'b0;
      req_rstart   <= 1'b0;
      req_stop     <= 1'b0;
      ack_en       <= 1'b0;
      pins_release <= 1'b1;
    end else begin
      req_start    <= idle_go;
      req_rstart   <= rep_go;
      req_stop     <= stop_go;
      ack_en       <= ctrl.ack;
      pins_release <= !ctrl.pe;
    end
  end
endmodule

// File: rtl/i2cm_evt_gate.sv
module i2cm_evt_gate #(
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pe,
  input  logic               ite,
  input  logic [NUM_EVT-1:0] flags,
  output logic               irq,
  output logic               scl_hold
);
  logic [NUM_EVT-1:0] live;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_mask
    assign live[i] = flags[i] & pe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      irq      <= ite && (|live);
      scl_hold <= |live;
    end
  end
endmodule

// File: rtl/i2cm_ctrl_front.sv
module i2cm_ctrl_front
  import i2cm_ctrl_pkg::*;
#(
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_wr,
  input  logic [REG_W-1:0]   cpu_wdata,
  output logic [REG_W-1:0]   cpu_rdata,
  input  logic               eng_start_sent,
  input  logic               eng_stop_sent,
  input  logic               eng_master,
  input  logic               eng_bus_busy,
  input  logic [NUM_EVT-1:0] eng_flags,
  output logic               req_start,
  output logic               req_rstart,
  output logic               req_stop,
  output logic               ack_en,
  output logic               irq,
  output logic               scl_hold,
  output logic               pins_release
);
  ctrl_t ctrl;

  i2cm_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr(cpu_wr), .wdata(cpu_wdata),
    .start_sent(eng_start_sent), .stop_sent(eng_stop_sent), .ctrl(ctrl)
  );

  i2cm_cmd_seq u_seq (
    .clk(clk), .rst(rst), .ctrl(ctrl), .master(eng_master), .busy(eng_bus_busy),
    .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
    .ack_en(ack_en), .pins_release(pins_release)
  );

  i2cm_evt_gate #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk(clk), .rst(rst), .pe(ctrl.pe), .ite(ctrl.ite), .flags(eng_flags),
    .irq(irq), .scl_hold(scl_hold)
  );

  assign cpu_rdata = pack_ctrl(ctrl);
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk #(
  parameter int NUM_EVT = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_wr,
  input logic [7:0]         cpu_wdata,
  input logic [7:0]         cpu_rdata,
  input logic               eng_start_sent,
  input logic               eng_stop_sent,
  input logic               req_start,
  input logic               req_rstart,
  input logic               irq
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[7:6] == 2'b00 && cpu_rdata[4] == 1'b0);

  a_r2_first_write_pe_only: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_rdata[5] && cpu_wdata[5]) |=>
      (cpu_rdata[5] && !cpu_rdata[3] && !cpu_rdata[2] && !cpu_rdata[0]));

  a_r4_disabled_clear: assert property (@(posedge clk) disable iff (rst)
    !cpu_rdata[5] |-> (cpu_rdata[3:2] == 2'b00 && !cpu_rdata[0]));

  a_r5_start_hw_clear: assert property (@(posedge clk) disable iff (rst)
    eng_start_sent |=> !cpu_rdata[3]);

  a_r8_stop_kept: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata[1] && !eng_stop_sent && !cpu_wr) |=> cpu_rdata[1]);

  a_r7_one_start_kind: assert property (@(posedge clk) disable iff (rst)
    !(req_start && req_rstart));

  a_r10_irq_needs_ite: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cpu_rdata[0]));
endmodule

bind i2cm_ctrl_front i2cm_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata), .eng_start_sent(eng_start_sent),
  .eng_stop_sent(eng_stop_sent), .req_start(req_start),
  .req_rstart(req_rstart), .irq(irq)
);

// File: tb/tb_i2cm_ctrl_front.sv
module tb_i2cm_ctrl_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       eng_start_sent = 1'b0, eng_stop_sent = 1'b0;
  logic       eng_master = 1'b0, eng_bus_busy = 1'b0;
  logic [2:0] eng_flags = '0;
  logic       req_start, req_rstart, req_stop, ack_en, irq, scl_hold, pins_release;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  i2cm_ctrl_front #(.NUM_EVT(3)) dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .eng_start_sent(eng_start_sent),
    .eng_stop_sent(eng_stop_sent), .eng_master(eng_master),
    .eng_bus_busy(eng_bus_busy), .eng_flags(eng_flags),
    .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
    .ack_en(ack_en), .irq(irq), .scl_hold(scl_hold), .pins_release(pins_release)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_wr = 1'b0; eng_master = 1'b0; eng_bus_busy = 1'b0; eng_flags = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 reset", cpu_rdata, 8'h00);
    chk("R4 reset release", {7'b0, pins_release}, 8'h01);

    // R2: every first write from the disabled state
    for (int d = 0; d < 256; d++) begin
      do_reset();
      wr(d[7:0]);
      chk("R2 first write", cpu_rdata, d[5] ? 8'h20 : 8'h00);
    end

    // R3/R4/R1: every second write from the enabled state
    for (int d = 0; d < 256; d++) begin
      do_reset();
      wr(8'h20);
      wr(d[7:0]);
      chk("R3 second write", cpu_rdata, d[5] ? (d[7:0] & 8'h2F) : 8'h00);
      tick();
      chk("R4 release", {7'b0, pins_release}, d[5] ? 8'h00 : 8'h01);
      chk("R9 ack_en", {7'b0, ack_en}, {7'b0, d[5] & d[2]});
    end

    // R4 stop survives disable, R8 stop_sent clears while disabled
    do_reset(); wr(8'h20); wr(8'h22); wr(8'h00);
    chk("R4 stop kept", cpu_rdata, 8'h02);
    eng_stop_sent = 1'b1; tick(); eng_stop_sent = 1'b0;
    chk("R8 stop cleared", cpu_rdata, 8'h00);

    // R12 software clears stop
    do_reset(); wr(8'h20); wr(8'h22); wr(8'h20);
    chk("R12 stop write 0", cpu_rdata, 8'h20);

    // R5 hardware clear wins over same-cycle write
    do_reset(); wr(8'h20);
    eng_start_sent = 1'b1; wr(8'h28); eng_start_sent = 1'b0;
    chk("R5 clear wins", cpu_rdata, 8'h20);
    wr(8'h28);
    eng_start_sent = 1'b1; tick(); eng_start_sent = 1'b0;
    chk("R5 start_sent clears", cpu_rdata, 8'h20);

    // R6/R7/R8 command sweep
    for (int k = 0; k < 16; k++) begin
      logic m, b, s, p;
      {m, b, s, p} = k[3:0];
      do_reset(); wr(8'h20); wr({4'h2, s, 1'b0, p, 1'b0});
      eng_master = m; eng_bus_busy = b;
      tick();
      chk("R6 req_start", {7'b0, req_start}, {7'b0, s & !m & !b});
      chk("R7 req_rstart", {7'b0, req_rstart}, {7'b0, s & m & !p});
      chk("R8 req_stop", {7'b0, req_stop}, {7'b0, p & m});
    end

    // R10/R11 flag sweep
    for (int k = 0; k < 16; k++) begin
      logic ie;
      ie = k[3];
      do_reset(); wr(8'h20); wr({7'h10, ie});
      eng_flags = k[2:0];
      tick();
      chk("R10 irq", {7'b0, irq}, {7'b0, ie & (|k[2:0])});
      chk("R11 scl_hold", {7'b0, scl_hold}, {7'b0, |k[2:0]});
    end

    // R11 flags masked while disabled
    do_reset(); eng_flags = 3'b111; tick(); tick();
    chk("R11 disabled no hold", {6'b0, scl_hold, irq}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule